// File: doc/BRIEF.md
# I/O and ROM Address Window Decoder

This block places a peripheral inside a 64K I/O space and, optionally, a boot ROM inside a 24-bit memory space. A 16-bit setup word holds both window bases and the ROM size code. The word can be written all at once by a configuration loader, or one byte lane at a time by the host. Every incoming I/O address is fully decoded against the stored base. A hit raises an I/O select and passes the four low address bits out as a register offset. Every memory address is compared against the ROM base over a span set by the size code. A hit raises a ROM select during read cycles only.

The block also steers a single interrupt request onto one of four interrupt pins. Each pin is modelled as an output-enable and data pair, so exactly one pin drives at any time and the other three float. When the alternate card mode input is high, the I/O window is pinned to its reset base and host writes to the setup word are refused.

Setup word layout: bits 15..8 are I/O base bits A15, A14, A13, A9, A8, A7, A6, A5 (bit 15 first). Bits 7..6 are the ROM size code. Bits 5..1 are ROM base bits RA18..RA14 (bit 5 = RA18). Bit 0 is stored but not decoded. The reset value is 1867h, which gives an I/O base of 300h, a 16K ROM window and a ROM base of CC000h.

Top module: `addr_window_dec`

## Requirements
- R1: A synchronous reset sets the setup word to 1867h. Afterwards I/O addresses 300h..30Fh are selected, and a read at CC000h..CFFFFh selects the ROM.
- R2: io_sel is high when io_addr[15:13] and io_addr[9:5] equal setup bits 15..13 and 12..8. While io_sel is high, io_ofs equals io_addr[3:0]; otherwise io_ofs is 0.
- R3: io_sel stays low whenever any of io_addr bits 12, 11, 10 or 4 is 1.
- R4: Size code 00 disables the ROM window, so rom_sel stays low for every address.
- R5: Size code 01 compares mem_addr[18:14] with setup bits 5..1. Code 10 compares mem_addr[18:15] with setup bits 5..2. Code 11 compares mem_addr[18:16] with setup bits 5..3. Address bits below the compared span are ignored.
- R6: rom_sel requires mem_addr[19] = 1 and mem_addr[23:20] = 0.
- R7: rom_sel is high only while the active-low mem_rd_n is 0. A write cycle never selects the ROM.
- R8: A cfg_load pulse writes all 16 bits of cfg_word in one clock. It takes priority over a host write in the same cycle.
- R9: A host write updates only the byte lanes whose host_be bit is set (host_be[1] = bits 15..8, host_be[0] = bits 7..0).
- R10: While card_mode is 1, the I/O window uses base 300h whatever the stored bits are, and host writes leave the setup word unchanged.
- R11: irq_oe is one-hot, with bit irq_sel set. irq_out[irq_sel] equals irq_req, and every other irq_out bit is 0.
- R12: io_sel, io_ofs and rom_sel follow the address inputs in the same cycle. A setup change takes effect only after the rising clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| card_mode | input | 1 | Alternate card mode: fixed I/O base, host writes refused |
| cfg_load | input | 1 | Load strobe for the full setup word |
| cfg_word | input | 16 | Setup word from the configuration loader |
| host_we | input | 1 | Host write strobe |
| host_be | input | 2 | Host byte enables |
| host_wdata | input | 16 | Host write data |
| io_addr | input | 16 | I/O address under decode |
| io_sel | output | 1 | I/O window hit |
| io_ofs | output | 4 | Register offset inside the window |
| mem_addr | input | 24 | Memory address under decode |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| rom_sel | output | 1 | ROM window read hit |
| irq_req | input | 1 | Interrupt request to route |
| irq_sel | input | 2 | Interrupt pin choice |
| irq_oe | output | 4 | Per-pin output enable |
| irq_out | output | 4 | Per-pin drive value |

## Verification
The bench probes addresses one bit away from a hit: one of the must-be-zero lines A12, A11, A10 or A4 set, A19 cleared, or one A23..A20 line set. A decoder that masked those lines instead of requiring zero would select an aliased window. Each ROM size code is paired with an address that differs only in the lowest compared bit or in the highest ignored bit. A wrong span would miss a valid hit or accept a stray address. Further probes cover a simultaneous load and host write, a host write during card mode, and a probe taken in the same cycle as a load. A design that let the host win, that let card mode through, or that decoded from the incoming word before the edge would report the wrong window.

// File: rtl/addr_window_pkg.sv
`timescale 1ns/1ps
package addr_window_pkg;

   localparam int SETUP_W = 16;
   localparam logic [SETUP_W-1:0] SETUP_DEF = 16'h1867;

   typedef enum logic [1:0] {
      ROM_OFF = 2'b00,
      ROM_16K = 2'b01,
      ROM_32K = 2'b10,
      ROM_64K = 2'b11
   } rom_size_e;

   typedef struct packed {
      logic [2:0] io_hi;     // A15..A13
      logic [4:0] io_mid;    // A9..A5
      rom_size_e  rom_sz;
      logic [4:0] rom_base;  // RA18..RA14
      logic       spare;
   } setup_t;

endpackage

// File: rtl/aw_setup_reg.sv
`timescale 1ns/1ps
module aw_setup_reg #(
   parameter int W = 16,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           lock,
   input  logic           ld,
   input  logic [W-1:0]   ld_data,
   input  logic           we,
   input  logic [W/8-1:0] be,
   input  logic [W-1:0]   wdata,
   output logic [W-1:0]   q
);
   localparam int NB = W / 8;

   for (genvar g = 0; g < NB; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)
            q[g*8 +: 8] <= RST_VAL[g*8 +: 8];
         else if (ld)
            q[g*8 +: 8] <= ld_data[g*8 +: 8];
         else if (we && be[g] && !lock)
            q[g*8 +: 8] <= wdata[g*8 +: 8];
      end
   end
endmodule

// File: rtl/aw_io_match.sv
`timescale 1ns/1ps
module aw_io_match #(
   parameter int AW    = 16,
   parameter int OFS_W = 4
) (
   input  logic [AW-1:0]    addr,
   input  logic [2:0]       base_hi,
   input  logic [4:0]       base_mid,
   output logic             hit,
   output logic [OFS_W-1:0] ofs
);
   logic hi_eq, mid_eq, zeros_ok;

   always_comb begin
      hi_eq    = (addr[15:13] == base_hi);
      mid_eq   = (addr[9:5] == base_mid);
      zeros_ok = (addr[12:10] == 3'b000) && !addr[4];
      hit      = hi_eq && mid_eq && zeros_ok;
      ofs      = hit ? addr[OFS_W-1:0] : '0;
   end
endmodule

// File: rtl/aw_rom_match.sv
`timescale 1ns/1ps
module aw_rom_match
   import addr_window_pkg::*;
#(
   parameter int AW = 24
) (
   input  logic [AW-1:0] addr,
   input  logic          rd_n,
   input  rom_size_e     sz,
   input  logic [4:0]    base,
   output logic          hit
);
   logic [4:0] cmp_mask;
   logic       span_eq, page_ok;

   always_comb begin
      unique case (sz)
         ROM_16K: cmp_mask = 5'b11111;
         ROM_32K: cmp_mask = 5'b11110;
         ROM_64K: cmp_mask = 5'b11100;
         default: cmp_mask = 5'b00000;
      endcase
      span_eq = ((addr[18:14] ^ base) & cmp_mask) == 5'b00000;
      page_ok = addr[19] && (addr[AW-1:20] == '0);
      hit     = (sz != ROM_OFF) && span_eq && page_ok && !rd_n;
   end
endmodule

// File: rtl/aw_irq_route.sv
`timescale 1ns/1ps
module aw_irq_route #(
   parameter int N = 4,
   localparam int SW = $clog2(N)
) (
   input  logic          req,
   input  logic [SW-1:0] sel,
   output logic [N-1:0]  oe,
   output logic [N-1:0]  dout
);
   for (genvar p = 0; p < N; p++) begin : g_pin
      assign oe[p]   = (sel == SW'(p));
      assign dout[p] = oe[p] & req;
   end
endmodule

// File: rtl/addr_window_dec.sv
`timescale 1ns/1ps
module addr_window_dec
   import addr_window_pkg::*;
#(
   parameter int IO_AW  = 16,
   parameter int MEM_AW = 24,
   parameter int N_IRQ  = 4,
   localparam int OFS_W = 4,
   localparam int SEL_W = $clog2(N_IRQ),
   localparam int NB    = SETUP_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              card_mode,
   input  logic              cfg_load,
   input  logic [SETUP_W-1:0] cfg_word,
   input  logic              host_we,
   input  logic [NB-1:0]     host_be,
   input  logic [SETUP_W-1:0] host_wdata,
   input  logic [IO_AW-1:0]  io_addr,
   output logic              io_sel,
   output logic [OFS_W-1:0]  io_ofs,
   input  logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_rd_n,
   output logic              rom_sel,
   input  logic              irq_req,
   input  logic [SEL_W-1:0]  irq_sel,
   output logic [N_IRQ-1:0]  irq_oe,
   output logic [N_IRQ-1:0]  irq_out
);
   if (IO_AW != 16) begin : g_bad_io
      $error("addr_window_dec: IO_AW must be 16");
   end
   if (MEM_AW != 24) begin : g_bad_mem
      $error("addr_window_dec: MEM_AW must be 24");
   end
   if (N_IRQ < 2 || (1 << SEL_W) != N_IRQ) begin : g_bad_irq
      $error("addr_window_dec: N_IRQ must be a power of two, at least 2");
   end

   logic [SETUP_W-1:0] setup_q;
   setup_t             setup_s;
   setup_t             def_s;
   logic [2:0]         eff_hi;
   logic [4:0]         eff_mid;

   aw_setup_reg #(.W(SETUP_W), .RST_VAL(SETUP_DEF)) u_setup (
      .clk    (clk),
      .rst    (rst),
      .lock   (card_mode),
      .ld     (cfg_load),
      .ld_data(cfg_word),
      .we     (host_we),
      .be     (host_be),
      .wdata  (host_wdata),
      .q      (setup_q)
   );

   assign setup_s = setup_t'(setup_q);
   assign def_s   = setup_t'(SETUP_DEF);
   assign eff_hi  = card_mode ? def_s.io_hi  : setup_s.io_hi;
   assign eff_mid = card_mode ? def_s.io_mid : setup_s.io_mid;

   aw_io_match #(.AW(IO_AW), .OFS_W(OFS_W)) u_io (
      .addr    (io_addr),
      .base_hi (eff_hi),
      .base_mid(eff_mid),
      .hit     (io_sel),
      .ofs     (io_ofs)
   );

   aw_rom_match #(.AW(MEM_AW)) u_rom (
      .addr(mem_addr),
      .rd_n(mem_rd_n),
      .sz  (setup_s.rom_sz),
      .base(setup_s.rom_base),
      .hit (rom_sel)
   );

   aw_irq_route #(.N(N_IRQ)) u_irq (
      .req (irq_req),
      .sel (irq_sel),
      .oe  (irq_oe),
      .dout(irq_out)
   );
endmodule

// File: rtl/addr_window_chk.sv
`timescale 1ns/1ps
module addr_window_chk
   import addr_window_pkg::*;
#(
   parameter int N_IRQ = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              card_mode,
   input logic              cfg_load,
   input logic              host_we,
   input logic [SETUP_W-1:0] setup_q,
   input logic [15:0]       io_addr,
   input logic              io_sel,
   input logic [3:0]        io_ofs,
   input logic [23:0]       mem_addr,
   input logic              mem_rd_n,
   input logic              rom_sel,
   input logic [N_IRQ-1:0]  irq_oe,
   input logic [N_IRQ-1:0]  irq_out
);
   p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> setup_q == SETUP_DEF);

   p_ofs_passthru_r2: assert property (@(posedge clk) disable iff (rst)
      io_sel |-> io_ofs == io_addr[3:0]);

   p_ofs_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !io_sel |-> io_ofs == 4'h0);

   p_io_zero_lines_r3: assert property (@(posedge clk) disable iff (rst)
      io_sel |-> (io_addr[12:10] == 3'b000 && !io_addr[4]));

   p_rom_page_r6: assert property (@(posedge clk) disable iff (rst)
      rom_sel |-> (mem_addr[19] && mem_addr[23:20] == 4'h0));

   p_rom_read_only_r7: assert property (@(posedge clk) disable iff (rst)
      rom_sel |-> !mem_rd_n);

   p_setup_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!cfg_load && !host_we) |=> $stable(setup_q));

   p_card_base_r10: assert property (@(posedge clk) disable iff (rst)
      (card_mode && io_sel) |-> (io_addr[15:13] == 3'b000 && io_addr[9:5] == 5'b11000));

   p_card_lock_r10: assert property (@(posedge clk) disable iff (rst)
      (card_mode && !cfg_load) |=> $stable(setup_q));

   p_irq_onehot_r11: assert property (@(posedge clk) disable iff (rst)
      $countones(irq_oe) == 1);

   p_irq_float_r11: assert property (@(posedge clk) disable iff (rst)
      (irq_out & ~irq_oe) == '0);
endmodule

bind addr_window_dec addr_window_chk #(.N_IRQ(N_IRQ)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .card_mode(card_mode),
   .cfg_load (cfg_load),
   .host_we  (host_we),
   .setup_q  (setup_q),
   .io_addr  (io_addr),
   .io_sel   (io_sel),
   .io_ofs   (io_ofs),
   .mem_addr (mem_addr),
   .mem_rd_n (mem_rd_n),
   .rom_sel  (rom_sel),
   .irq_oe   (irq_oe),
   .irq_out  (irq_out)
);

// File: tb/addr_window_dec_test.sv
`timescale 1ns/1ps
module addr_window_dec_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        card_mode = 1'b0;
   logic        cfg_load = 1'b0;
   logic [15:0] cfg_word = '0;
   logic        host_we = 1'b0;
   logic [1:0]  host_be = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] io_addr = '0;
   logic        io_sel;
   logic [3:0]  io_ofs;
   logic [23:0] mem_addr = '0;
   logic        mem_rd_n = 1'b1;
   logic        rom_sel;
   logic        irq_req = 1'b0;
   logic [1:0]  irq_sel = '0;
   logic [3:0]  irq_oe;
   logic [3:0]  irq_out;

   always #2 clk = ~clk;   // 250 MHz

   addr_window_dec uut (
      .clk(clk), .rst(rst), .card_mode(card_mode),
      .cfg_load(cfg_load), .cfg_word(cfg_word),
      .host_we(host_we), .host_be(host_be), .host_wdata(host_wdata),
      .io_addr(io_addr), .io_sel(io_sel), .io_ofs(io_ofs),
      .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .rom_sel(rom_sel),
      .irq_req(irq_req), .irq_sel(irq_sel),
      .irq_oe(irq_oe), .irq_out(irq_out)
   );

   typedef struct {
      logic       io;
      logic [3:0] ofs;
      logic       rom;
      logic [3:0] oe;
      logic [3:0] dout;
      string      tag;
   } exp_t;

   exp_t        sb_q[$];
   event        ev_chk;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [15:0] m_setup = 16'h1867;
   bit          m_card = 1'b0;

   function automatic logic model_io(input logic [15:0] a);
      logic [7:0] b;
      b = m_card ? 8'h18 : m_setup[15:8];
      return (a[15:13] == b[7:5]) && (a[9:5] == b[4:0]) &&
             (a[12:10] == 3'b000) && !a[4];
   endfunction

   function automatic logic model_rom(input logic [23:0] a, input logic rdn);
      logic [4:0] b;
      logic       m;
      b = m_setup[5:1];
      case (m_setup[7:6])
         2'b01:   m = (a[18:14] == b);
         2'b10:   m = (a[18:15] == b[4:1]);
         2'b11:   m = (a[18:16] == b[4:2]);
         default: m = 1'b0;
      endcase
      return m && a[19] && (a[23:20] == 4'h0) && !rdn;
   endfunction

   // driver: applies stimulus and queues the expected outputs
   task automatic probe(input logic [15:0] ia, input logic [23:0] ma,
                        input logic rdn, input logic rq, input logic [1:0] sl,
                        input string tag);
      exp_t e;
      io_addr  = ia;
      mem_addr = ma;
      mem_rd_n = rdn;
      irq_req  = rq;
      irq_sel  = sl;
      e.io   = model_io(ia);
      e.ofs  = e.io ? ia[3:0] : 4'h0;
      e.rom  = model_rom(ma, rdn);
      e.oe   = 4'b0001 << sl;
      e.dout = rq ? e.oe : 4'b0000;
      e.tag  = tag;
      sb_q.push_back(e);
      -> ev_chk;
   endtask

   task automatic step_probe(input logic [15:0] ia, input logic [23:0] ma,
                             input logic rdn, input string tag);
      @(negedge clk);
      probe(ia, ma, rdn, 1'b0, 2'd0, tag);
   endtask

   task automatic load_cfg(input logic [15:0] w);
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_word = w;
      @(negedge clk);
      cfg_load = 1'b0;
      m_setup  = w;
   endtask

   task automatic host_wr(input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      host_we    = 1'b1;
      host_be    = be;
      host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
      if (!m_card) begin
         if (be[1]) m_setup[15:8] = d[15:8];
         if (be[0]) m_setup[7:0]  = d[7:0];
      end
   endtask

   // monitor: pops expected items and compares away from the clock edge
   initial begin
      exp_t e;
      forever begin
         @(ev_chk);
         #1;
         while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if (io_sel !== e.io || io_ofs !== e.ofs || rom_sel !== e.rom ||
                irq_oe !== e.oe || irq_out !== e.dout) begin
               n_fail++;
               $display("FAIL %s: got io=%b ofs=%h rom=%b oe=%b out=%b, expected io=%b ofs=%h rom=%b oe=%b out=%b",
                        e.tag, io_sel, io_ofs, rom_sel, irq_oe, irq_out,
                        e.io, e.ofs, e.rom, e.oe, e.dout);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got run still active, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset defaults
      step_probe(16'h0305, 24'h0CC100, 1'b0, "R1 io 305h after reset");
      step_probe(16'h0300, 24'h0CFFFF, 1'b0, "R1 rom top of 16K after reset");

      // R2 compared bits and offset, R3 must-be-zero lines
      step_probe(16'h030F, 24'h000000, 1'b1, "R2 offset F");
      step_probe(16'h0320, 24'h000000, 1'b1, "R2 A5 mismatch");
      step_probe(16'h2300, 24'h000000, 1'b1, "R2 A13 mismatch");
      step_probe(16'h0700, 24'h000000, 1'b1, "R3 A10 set");
      step_probe(16'h0B00, 24'h000000, 1'b1, "R3 A11 set");
      step_probe(16'h1300, 24'h000000, 1'b1, "R3 A12 set");
      step_probe(16'h0310, 24'h000000, 1'b1, "R3 A4 set");

      // R12 load captured only at the edge: probe in the load cycle sees old base
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_word = 16'hE5A7;
      probe(16'h0305, 24'h000000, 1'b1, 1'b0, 2'd0, "R12 old base during load cycle");
      @(negedge clk);
      cfg_load = 1'b0;
      m_setup  = 16'hE5A7;
      probe(16'hE0A7, 24'h000000, 1'b1, 1'b0, 2'd0, "R12 new base after edge");
      step_probe(16'h0305, 24'h000000, 1'b1, "R8 old base gone after load");

      // R5 32K window: RA18..15 = 1001
      step_probe(16'h0000, 24'h0C8000, 1'b0, "R5 32K ignores RA14");
      step_probe(16'h0000, 24'h0C0000, 1'b0, "R5 32K RA15 mismatch");
      load_cfg(16'hE5E7);
      step_probe(16'h0000, 24'h0C0000, 1'b0, "R5 64K ignores RA15");
      step_probe(16'h0000, 24'h0D0000, 1'b0, "R5 64K RA16 mismatch");

      // R4 disabled
      load_cfg(16'hE527);
      step_probe(16'h0000, 24'h0CC000, 1'b0, "R4 size 00 no rom");

      // R6, R7 on 16K
      load_cfg(16'hE567);
      step_probe(16'h0000, 24'h0CC000, 1'b0, "R5 16K hit");
      step_probe(16'h0000, 24'h0C8000, 1'b0, "R5 16K RA14 mismatch");
      step_probe(16'h0000, 24'h04C000, 1'b0, "R6 A19 clear");
      step_probe(16'h0000, 24'h1CC000, 1'b0, "R6 A20 set");
      step_probe(16'h0000, 24'h8CC000, 1'b0, "R6 A23 set");
      step_probe(16'h0000, 24'h0CC000, 1'b1, "R7 write cycle");

      // R9 byte lanes
      host_wr(2'b10, 16'h1800);
      step_probe(16'h0305, 24'h0CC000, 1'b0, "R9 high lane only");
      host_wr(2'b01, 16'hFF27);
      step_probe(16'h0305, 24'h0CC000, 1'b0, "R9 low lane only");

      // R8 load beats host write
      @(negedge clk);
      cfg_load   = 1'b1;
      cfg_word   = 16'hE567;
      host_we    = 1'b1;
      host_be    = 2'b11;
      host_wdata = 16'h1800;
      @(negedge clk);
      cfg_load = 1'b0;
      host_we  = 1'b0;
      m_setup  = 16'hE567;
      probe(16'hE0A7, 24'h0CC000, 1'b0, 1'b0, 2'd0, "R8 load wins over host");

      // R10 card mode
      @(negedge clk);
      card_mode = 1'b1;
      m_card    = 1'b1;
      probe(16'h0305, 24'h000000, 1'b1, 1'b0, 2'd0, "R10 forced base hit");
      step_probe(16'hE0A7, 24'h000000, 1'b1, "R10 stored base ignored");
      host_wr(2'b11, 16'h0027);
      step_probe(16'h0305, 24'h0CC000, 1'b0, "R10 host write blocked");
      @(negedge clk);
      card_mode = 1'b0;
      m_card    = 1'b0;
      probe(16'hE0A7, 24'h0CC000, 1'b0, 1'b0, 2'd0, "R10 stored base intact");

      // R11 interrupt routing
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         probe(16'h0000, 24'h000000, 1'b1, 1'b1, 2'(s), "R11 route request");
      end
      @(negedge clk);
      probe(16'h0000, 24'h000000, 1'b1, 1'b0, 2'd2, "R11 idle request");

      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule